// File: doc/BRIEF.md
# Sliding-Window Clause Voting Classifier

This block sorts a 4x4 binary image into one of two classes using two banks of conjunctive clauses, one bank per class. A 2x2 window steps across the image one position at a time with stride 1, giving nine window positions. Each position contributes eight literals: its four pixel bits and their complements. Every clause ANDs the literals that its include mask selects. It is tested at each of the nine positions, and the clause counts as firing for the image when it fires at any position.

Each bank then adds up a signed vote: firing clauses at even indices count +1 and firing clauses at odd indices count -1. The class whose bank scores higher wins, and a tie goes to class 0. The include masks are written through a small write port and must not change while an image is being scanned. One scan takes nine cycles, one window position per cycle. A one-cycle done pulse marks the result, and the scores stay stable until the next accepted start.

Top module: `ctm_classifier`

## Requirements
- R1: While reset is asserted and right after it, busy and done are 0, every include mask is cleared, both scores read 0 and the predicted class reads 0.
- R2: A start seen while idle latches the image and raises busy on that edge. Done is high for exactly one cycle, on the 9th edge after the accepting edge, and busy falls on that same edge.
- R3: A start that arrives while busy is ignored. The scan in progress finishes on its normal schedule and reports the result for the image latched first.
- R4: Window positions run row-major over rows 0..2 and columns 0..2; image bit y*4+x holds pixel (y,x). At position (r,c), literal k for k in 0..3 is pixel (r+k/2, c+k%2), and literal 4+k is its complement. Mask bit k includes literal k. A clause fires at a position when every included literal is 1.
- R5: A clause whose mask is all zero never fires.
- R6: A clause fires for the image if it fires at one or more of the nine positions.
- R7: A bank's score is the number of firing even-indexed clauses minus the number of firing odd-indexed clauses, output as a signed value.
- R8: The predicted class is 1 only when score1 is strictly greater than score0; otherwise it is 0.
- R9: A mask write with cfg_we high stores cfg_mask to clause cfg_idx of bank cfg_bank (0 or 1). Writes with cfg_idx of 40 or more are dropped.
- R10: While idle, scores and the predicted class hold their last values whatever the image input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_bank | input | 1 | Bank select for the write |
| cfg_idx | input | 6 | Clause index for the write |
| cfg_mask | input | 8 | Include mask, bit k = literal k |
| start | input | 1 | Begin a scan of image |
| image | input | 16 | Pixel (y,x) at bit y*4+x |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result pulse |
| pred_class | output | 1 | Winning class |
| score0 | output | 7 | Signed vote sum, class 0 |
| score1 | output | 7 | Signed vote sum, class 1 |

## Verification
If a window position is skipped or an extra one is added, done moves away from the 9th edge, and the per-cycle comparison reports this on the first scan. If the window maps literals to the wrong pixels or complements, the score comes out wrong at the very next done. Directed images place a pixel at the lower-right corner patch and in the right-hand column, which no patch can reach at its top-left literal. If the firing state of a clause leaks from one scan into the next, or is lost before the scan ends, the difference shows in the score of that image once its scan finishes.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  // Class decision: class 1 must strictly beat class 0.
  function automatic logic winner(input int s0, input int s1);
    return (s1 > s0);
  endfunction
endpackage

// File: rtl/ctm_mask_file.sv
module ctm_mask_file #(
  parameter int N_CLAUSES = 40,
  parameter int LITS      = 8,
  localparam int IDX_W    = $clog2(N_CLAUSES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic                            bank,
  input  logic [IDX_W-1:0]                idx,
  input  logic [LITS-1:0]                 wdata,
  output logic [1:0][N_CLAUSES*LITS-1:0]  masks
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CLAUSES - 1);

  logic idx_ok;
  assign idx_ok = (idx <= LAST_IDX);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar c = 0; c < N_CLAUSES; c++) begin : g_cl
      always_ff @(posedge clk) begin
        if (!rst_n)
          masks[b][c*LITS +: LITS] <= '0;
        else if (we && idx_ok && (bank == b[0]) && (idx == IDX_W'(c)))
          masks[b][c*LITS +: LITS] <= wdata;
      end
    end
  end
endmodule

// File: rtl/ctm_scan_ctrl.sv
module ctm_scan_ctrl #(
  parameter int IMG_W = 4,
  parameter int WIN   = 2,
  localparam int NPOS = IMG_W - WIN + 1,
  localparam int PW   = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] row,
  output logic [PW-1:0] col
);
  localparam logic [PW-1:0] EDGE_POS = PW'(NPOS - 1);

  logic last;
  assign accept = start && !busy;
  assign last   = (row == EDGE_POS) && (col == EDGE_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      row  <= '0;
      col  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        row  <= '0;
        col  <= '0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (col == EDGE_POS) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  // R3: mid-scan, a new start never rewinds to the first position
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && !(row == '0 && col == '0)));

  // R2: done is a single-cycle pulse
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: busy ends exactly when done appears
  p_done_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/ctm_patch_mux.sv
module ctm_patch_mux #(
  parameter int IMG_W = 4,
  parameter int WIN   = 2,
  localparam int NPOS = IMG_W - WIN + 1,
  localparam int PW   = (NPOS > 1) ? $clog2(NPOS) : 1,
  localparam int NPIX = WIN * WIN,
  localparam int LITS = 2 * NPIX
) (
  input  logic [IMG_W*IMG_W-1:0] img,
  input  logic [PW-1:0]          row,
  input  logic [PW-1:0]          col,
  output logic [LITS-1:0]        lits
);
  logic [NPIX-1:0] pix;

  always_comb begin
    for (int dy = 0; dy < WIN; dy++)
      for (int dx = 0; dx < WIN; dx++)
        pix[dy*WIN + dx] = img[(int'(row) + dy) * IMG_W + int'(col) + dx];
  end

  assign lits = {~pix, pix};
endmodule

// File: rtl/ctm_clause_bank.sv
module ctm_clause_bank #(
  parameter int N_CLAUSES = 40,
  parameter int LITS      = 8,
  localparam int SW       = $clog2(N_CLAUSES + 1) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          en,
  input  logic [N_CLAUSES*LITS-1:0]     masks,
  input  logic [LITS-1:0]               lits,
  output logic signed [SW-1:0]          score
);
  logic [N_CLAUSES-1:0] hit;
  logic [N_CLAUSES-1:0] acc;

  function automatic logic signed [SW-1:0] tally(input logic [N_CLAUSES-1:0] a);
    logic signed [SW-1:0] s;
    s = '0;
    for (int i = 0; i < N_CLAUSES; i++)
      if (a[i]) s = s + ((i % 2 == 0) ? SW'(1) : {SW{1'b1}});
    return s;
  endfunction

  for (genvar c = 0; c < N_CLAUSES; c++) begin : g_clause
    logic [LITS-1:0] m;
    assign m      = masks[c*LITS +: LITS];
    assign hit[c] = (|m) && (&(lits | ~m));

    // R5: an empty clause that has not fired stays silent
    p_empty_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m == '0 && !acc[c] && !clear) |=> !acc[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (en)    acc <= acc | hit;
  end

  assign score = tally(acc);

  // R6: during a scan a clause that fired keeps its fired state
  p_acc_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clear) |=> ((~acc & $past(acc)) == '0));

  // R7: score stays within the half-bank span
  p_score_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(score) <= (N_CLAUSES + 1) / 2) && (int'(score) >= -(N_CLAUSES / 2)));
endmodule

// File: rtl/ctm_classifier.sv
module ctm_classifier #(
  parameter int IMG_W     = 4,
  parameter int WIN       = 2,
  parameter int N_CLAUSES = 40,
  localparam int NPOS     = IMG_W - WIN + 1,
  localparam int PW       = (NPOS > 1) ? $clog2(NPOS) : 1,
  localparam int LITS     = 2 * WIN * WIN,
  localparam int IDX_W    = $clog2(N_CLAUSES),
  localparam int SW       = $clog2(N_CLAUSES + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_bank,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [LITS-1:0]         cfg_mask,
  input  logic                    start,
  input  logic [IMG_W*IMG_W-1:0]  image,
  output logic                    busy,
  output logic                    done,
  output logic                    pred_class,
  output logic signed [SW-1:0]    score0,
  output logic signed [SW-1:0]    score1
);
  logic                           accept;
  logic [PW-1:0]                  row, col;
  logic [IMG_W*IMG_W-1:0]         img_q;
  logic [LITS-1:0]                lits;
  logic [1:0][N_CLAUSES*LITS-1:0] masks;
  logic signed [SW-1:0]           scores [2];

  ctm_mask_file #(.N_CLAUSES(N_CLAUSES), .LITS(LITS)) u_masks (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .bank(cfg_bank),
    .idx(cfg_idx), .wdata(cfg_mask), .masks(masks));

  ctm_scan_ctrl #(.IMG_W(IMG_W), .WIN(WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .busy(busy), .done(done), .row(row), .col(col));

  always_ff @(posedge clk) begin
    if (!rst_n)      img_q <= '0;
    else if (accept) img_q <= image;
  end

  ctm_patch_mux #(.IMG_W(IMG_W), .WIN(WIN)) u_patch (
    .img(img_q), .row(row), .col(col), .lits(lits));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ctm_clause_bank #(.N_CLAUSES(N_CLAUSES), .LITS(LITS)) u_bank (
      .clk(clk), .rst_n(rst_n), .clear(accept), .en(busy),
      .masks(masks[b]), .lits(lits), .score(scores[b]));
  end

  assign score0     = scores[0];
  assign score1     = scores[1];
  assign pred_class = ctm_pkg::winner(int'(score0), int'(score1));

  // R8: a tie always resolves to class 0
  p_tie_class0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && score0 == score1) |-> !pred_class);

  // R10: idle results are frozen unless a new scan is accepted
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(score0) && $stable(score1)));
endmodule

// File: tb/ctm_classifier_tb_top.sv
module ctm_classifier_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_bank, start;
  logic [5:0] cfg_idx;
  logic [7:0] cfg_mask;
  logic [15:0] image;
  logic busy, done, pred_class;
  logic signed [6:0] score0, score1;

  always #4ns clk = ~clk;

  ctm_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .start(start), .image(image),
    .busy(busy), .done(done), .pred_class(pred_class),
    .score0(score0), .score1(score1));

  int checks = 0;
  int errors = 0;
  bit [7:0] mmask [2][40];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_score(input int b, input logic [15:0] img);
    int s = 0;
    for (int c = 0; c < 40; c++) begin
      bit fired = 0;
      if (mmask[b][c] != 0) begin
        for (int r = 0; r < 3; r++)
          for (int q = 0; q < 3; q++) begin
            bit all1 = 1;
            for (int k = 0; k < 8; k++)
              if (mmask[b][c][k]) begin
                bit px = img[(r + (k % 4) / 2) * 4 + q + (k % 2)];
                if ((k < 4) ? !px : px) all1 = 0;
              end
            if (all1) fired = 1;
          end
      end
      if (fired) s += (c % 2 == 0) ? 1 : -1;
    end
    return s;
  endfunction

  // Behavioural model, advanced every clock
  bit m_busy, m_done;
  int m_cnt, m_s0, m_s1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_cnt <= 0; m_s0 <= 0; m_s1 <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy && start) begin
        m_busy <= 1; m_cnt <= 0;
        m_s0 <= ref_score(0, image);
        m_s1 <= ref_score(1, image);
      end else if (m_busy) begin
        if (m_cnt == 8) begin m_busy <= 0; m_done <= 1; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(done == m_done, "R2 done", done, m_done);
      if (!m_busy) begin
        chk(int'(score0) == m_s0, "R7 score0", score0, m_s0);
        chk(int'(score1) == m_s1, "R7 score1", score1, m_s1);
        chk(pred_class == (m_s1 > m_s0), "R8 pred", pred_class, m_s1 > m_s0);
      end
    end
  end

  task automatic wr(input int b, input int idx, input logic [7:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_bank = b[0]; cfg_idx = idx[5:0]; cfg_mask = m;
    @(negedge clk);
    cfg_we = 0;
    if (idx < 40) mmask[b][idx] = m;
  endtask

  task automatic run(input logic [15:0] img);
    @(negedge clk);
    start = 1; image = img;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_bank = 0; cfg_idx = 0; cfg_mask = 0;
    start = 0; image = 0;
    foreach (mmask[b, c]) mmask[b][c] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 busy/done", busy, 0);
    chk(score0 == 0 && score1 == 0 && !pred_class, "R1 outputs", score0, 0);
    rst_n = 1;

    // R5: empty masks never fire; tie gives class 0 (R8)
    run(16'hFFFF);
    chk(score0 == 0 && score1 == 0, "R5 empty clauses", score0, 0);
    chk(pred_class == 0, "R8 tie", pred_class, 0);

    // R4: pixel literal placement
    wr(0, 0, 8'h01);
    run(16'h0400);
    chk(score0 == 1, "R4 corner patch pixel", score0, 1);
    run(16'h0008);
    chk(score0 == 0, "R4 right column unreachable", score0, 0);

    // R6: only the last patch matches
    wr(1, 0, 8'h0F);
    run(16'hCC00);
    chk(score1 == 1, "R6 last patch", score1, 1);
    chk(pred_class == 0, "R8 tie 1:1", pred_class, 0);
    wr(1, 2, 8'h0F);
    run(16'hCC00);
    chk(pred_class == 1, "R8 class1 wins", pred_class, 1);

    // R7: odd clause votes against
    wr(0, 1, 8'h01);
    run(16'hCC00);
    chk(score0 == 0, "R7 odd vote", score0, 0);

    // R9: out-of-range index dropped
    wr(0, 40, 8'h01);
    run(16'hCC00);
    chk(score0 == 0, "R9 index 40 dropped", score0, 0);

    // R3: start during busy ignored
    @(negedge clk); start = 1; image = 16'hCC00;
    @(negedge clk); start = 0;
    @(negedge clk); start = 1; image = 16'h0000;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(score1 == 2, "R3 restart ignored", score1, 2);

    // R10: idle hold against image changes
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); image = 16'(i * 4099);
    end
    chk(score1 == 2 && pred_class == 1, "R10 hold", score1, 2);

    // Random masks and images (R4, R6, R7, R8)
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 40; c++)
        wr(b, c, 8'($urandom & $urandom & $urandom));
    for (int n = 0; n < 30; n++) begin
      logic [15:0] img = 16'($urandom);
      run(img);
      chk(int'(score0) == ref_score(0, img), "R4 random score0", score0, ref_score(0, img));
      chk(int'(score1) == ref_score(1, img), "R6 random score1", score1, ref_score(1, img));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule